// File: doc/BRIEF.md
# Serial Octal Switch Control Register

This block is the digital slave side of a bank of eight on/off switch controls programmed over a three-wire write stream. The stream has an active-low frame select, a serial clock and a serial data line. The block samples all three pins in its own system clock domain. While a frame is open, each falling serial clock edge moves one data bit into an eight-bit shift register, most significant bit first. When the frame closes, the shift register is copied into the switch register, which drives the eight switch-enable outputs. A one-cycle strobe marks each copy.

Every rising serial clock edge inside a frame drives the bit that leaves the top of the shift register onto an open-drain serial output. A device further down a daisy chain therefore receives each data bit eight serial clocks after this one did. The same output can also be used to read back the shift register. Frames may be shorter or longer than eight bits; only the eight most recent bits are latched. The system clock must run at least four times faster than the serial clock.

Top module: `sw8_serial_ctrl`

## Requirements
- R1: While frame select is low, each falling serial clock edge shifts the data input into bit 0 of the shift register and moves every other bit up one place. The first bit sent therefore ends up in bit 7.
- R2: On the rising edge of frame select, the switch register is loaded with the shift register contents. At no other time does the switch register change.
- R3: A frame of any length leaves the shift register holding the last eight bits received. In a frame with fewer than eight bits, the older bits move up by the number of bits received.
- R4: While frame select is high, activity on the serial clock and data input leaves the shift register unchanged.
- R5: Switch-enable output bit k controls switch k+1, so bit 7 is switch 8 and bit 0 is switch 1. A 1 turns the switch on, and any pattern is allowed.
- R6: On each rising serial clock edge inside a frame, the serial output takes the value of shift register bit 7. It holds that value at all other times. A bit that enters at a falling edge is presented before the eighth falling edge after it.
- R7: The serial output is open-drain. `sdo_low_o` = 1 means the pin pulls low (a 0); `sdo_low_o` = 0 means the pin is released (a 1).
- R8: While `rst` is high, both registers are cleared: all switches are off, the strobe is low, and the serial output drives low.
- R9: `upd_o` is high for exactly one cycle for each frame-select rising edge.
- R10: A frame that contains no serial clock edges still reloads the switch register from the current shift register and pulses `upd_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must be at least four times the serial clock rate |
| rst | input | 1 | Synchronous active-high reset |
| fs_n_i | input | 1 | Frame select, active low, asynchronous to clk |
| sclk_i | input | 1 | Serial clock, asynchronous to clk |
| sdi_i | input | 1 | Serial data in |
| sw_en_o | output | NSW | Switch enables; bit k drives switch k+1 |
| upd_o | output | 1 | One-cycle strobe when the switch register is loaded |
| sdo_low_o | output | 1 | Open-drain serial output; 1 pulls low, 0 releases |

## Verification
The main function is tried with the following patterns:
- Exact eight-bit frames with mixed, all-ones and all-zeros values. These separate bit order and switch mapping.
- A sixteen-bit frame. It shows that only the last byte is latched, and its serial output, captured at each falling edge, must return the previous byte followed by the first byte of the frame.
- A four-bit frame. It shows that the older bits move up rather than being cleared.
- Serial clock pulses while the frame is closed, followed by an empty frame. Together they show that the ignored clocks left the shift register alone and that the empty frame still latches.
- A nine-bit frame. It makes the open-drain output release for a 1.

A reset in the middle of the run confirms that everything clears.

// File: rtl/sw8_ser_pkg.sv
package sw8_ser_pkg;

  // Positions of the three serial pins in the synchronized vector
  localparam int PIN_FS   = 0;
  localparam int PIN_SCLK = 1;
  localparam int PIN_DIN  = 2;
  localparam int NPIN     = 3;

  // Level each pin has when the bus is idle (frame select high)
  localparam logic [NPIN-1:0] PIN_IDLE = 3'b001;

  // Edge events the control logic needs
  localparam int EV_FS_RISE   = 0;
  localparam int EV_SCLK_RISE = 1;
  localparam int EV_SCLK_FALL = 2;
  localparam int NEV          = 3;

  // Which synchronized pin each event watches
  function automatic int ev_src(input int ev);
    case (ev)
      EV_FS_RISE:   return PIN_FS;
      EV_SCLK_RISE: return PIN_SCLK;
      default:      return PIN_SCLK;
    endcase
  endfunction

  // 1 when the event is a rising edge, 0 for a falling edge
  function automatic bit ev_rising(input int ev);
    return (ev != EV_SCLK_FALL);
  endfunction

endpackage

// File: rtl/sw8_pin_sync.sv
module sw8_pin_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic lvl_o
);

  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe <= {STAGES{RST_VAL}};
    end else begin
      pipe <= {pipe[STAGES-2:0], pin_i};
    end
  end

  assign lvl_o = pipe[STAGES-1];

endmodule

// File: rtl/sw8_edge_det.sv
module sw8_edge_det #(
  parameter bit   RISING  = 1'b1,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  output logic ev_o
);

  logic prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= RST_VAL;
    end else begin
      prev <= lvl_i;
    end
  end

  generate
    if (RISING) begin : g_rise
      assign ev_o = lvl_i & ~prev;
    end else begin : g_fall
      assign ev_o = ~lvl_i & prev;
    end
  endgenerate

endmodule

// File: rtl/sw8_shift_core.sv
module sw8_shift_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         frame_idle,
  input  logic         sclk_rise,
  input  logic         sclk_fall,
  input  logic         din_lvl,
  output logic [W-1:0] sr_o,
  output logic         sdo_low_o
);

  // Shift on the serial falling edge; present the outgoing MSB on the
  // serial rising edge so it is settled at the downstream falling edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      sr_o      <= '0;
      sdo_low_o <= 1'b1;
    end else if (!frame_idle) begin
      if (sclk_fall) begin
        sr_o <= {sr_o[W-2:0], din_lvl};
      end
      if (sclk_rise) begin
        sdo_low_o <= ~sr_o[W-1];
      end
    end
  end

endmodule

// File: rtl/sw8_switch_reg.sv
module sw8_switch_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] sr_i,
  output logic [W-1:0] sw_o,
  output logic         upd_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_o  <= '0;
      upd_o <= 1'b0;
    end else begin
      upd_o <= load_i;
      if (load_i) begin
        sw_o <= sr_i;
      end
    end
  end

endmodule

// File: rtl/sw8_serial_ctrl.sv
module sw8_serial_ctrl
  import sw8_ser_pkg::*;
#(
  parameter int NSW         = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           fs_n_i,
  input  logic           sclk_i,
  input  logic           sdi_i,
  output logic [NSW-1:0] sw_en_o,
  output logic           upd_o,
  output logic           sdo_low_o
);

  logic [NPIN-1:0] pin_raw;
  logic [NPIN-1:0] pin_lvl;
  logic [NEV-1:0]  ev;

  logic           frame_idle;
  logic           sclk_rise;
  logic           sclk_fall;
  logic           din_lvl;
  logic [NSW-1:0] shreg;

  assign pin_raw[PIN_FS]   = fs_n_i;
  assign pin_raw[PIN_SCLK] = sclk_i;
  assign pin_raw[PIN_DIN]  = sdi_i;

  generate
    for (genvar p = 0; p < NPIN; p++) begin : g_sync
      sw8_pin_sync #(
        .STAGES (SYNC_STAGES),
        .RST_VAL(PIN_IDLE[p])
      ) sync_i (
        .clk  (clk),
        .rst  (rst),
        .pin_i(pin_raw[p]),
        .lvl_o(pin_lvl[p])
      );
    end

    for (genvar e = 0; e < NEV; e++) begin : g_edge
      sw8_edge_det #(
        .RISING (ev_rising(e)),
        .RST_VAL(PIN_IDLE[ev_src(e)])
      ) edge_i (
        .clk  (clk),
        .rst  (rst),
        .lvl_i(pin_lvl[ev_src(e)]),
        .ev_o (ev[e])
      );
    end
  endgenerate

  assign frame_idle = pin_lvl[PIN_FS];
  assign din_lvl    = pin_lvl[PIN_DIN];
  assign sclk_rise  = ev[EV_SCLK_RISE];
  assign sclk_fall  = ev[EV_SCLK_FALL];

  sw8_shift_core #(
    .W(NSW)
  ) core_i (
    .clk       (clk),
    .rst       (rst),
    .frame_idle(frame_idle),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .din_lvl   (din_lvl),
    .sr_o      (shreg),
    .sdo_low_o (sdo_low_o)
  );

  sw8_switch_reg #(
    .W(NSW)
  ) swreg_i (
    .clk   (clk),
    .rst   (rst),
    .load_i(ev[EV_FS_RISE]),
    .sr_i  (shreg),
    .sw_o  (sw_en_o),
    .upd_o (upd_o)
  );

endmodule

// File: rtl/sw8_serial_ctrl_chk.sv
module sw8_serial_ctrl_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         frame_idle,
  input logic         sclk_rise,
  input logic         sclk_fall,
  input logic         din_lvl,
  input logic [W-1:0] shreg,
  input logic [W-1:0] sw_en_o,
  input logic         upd_o,
  input logic         sdo_low_o
);

  AST_SHIFT_MSB_FIRST: assert property (@(posedge clk) disable iff (rst)
    (!frame_idle && sclk_fall) |=> (shreg == {$past(shreg[W-2:0]), $past(din_lvl)})); // R1

  AST_LATCH_COPY: assert property (@(posedge clk) disable iff (rst)
    upd_o |-> (sw_en_o == $past(shreg))); // R2

  AST_SW_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!upd_o && !$past(rst)) |-> $stable(sw_en_o)); // R2

  AST_IDLE_NO_SHIFT: assert property (@(posedge clk) disable iff (rst)
    frame_idle |=> $stable(shreg)); // R4

  AST_SDO_QUIET: assert property (@(posedge clk) disable iff (rst)
    !(sclk_rise && !frame_idle) |=> $stable(sdo_low_o)); // R6

  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (sw_en_o == '0 && !upd_o && sdo_low_o)); // R8

  AST_UPD_SINGLE: assert property (@(posedge clk) disable iff (rst)
    upd_o |=> !upd_o); // R9

endmodule

bind sw8_serial_ctrl sw8_serial_ctrl_chk #(.W(NSW)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .frame_idle(frame_idle),
  .sclk_rise (sclk_rise),
  .sclk_fall (sclk_fall),
  .din_lvl   (din_lvl),
  .shreg     (shreg),
  .sw_en_o   (sw_en_o),
  .upd_o     (upd_o),
  .sdo_low_o (sdo_low_o)
);

// File: tb/sw8_serial_ctrl_tb.sv
`timescale 1ns/1ps
module sw8_serial_ctrl_tb_top;

  localparam int HALF = 4;   // serial half period in system clocks

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fs_n = 1'b1;
  logic       sclk = 1'b0;
  logic       sdi = 1'b0;
  logic [7:0] sw_en;
  logic       upd;
  logic       sdo_low;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int upd_cnt = 0;
  bit done = 1'b0;
  logic [31:0] cap;

  always #5 clk = ~clk;

  sw8_serial_ctrl dut_i (
    .clk      (clk),
    .rst      (rst),
    .fs_n_i   (fs_n),
    .sclk_i   (sclk),
    .sdi_i    (sdi),
    .sw_en_o  (sw_en),
    .upd_o    (upd),
    .sdo_low_o(sdo_low)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: pin history queue, two-cycle sampling delay,
  // edges judged between the delayed sample and the one before it.
  logic [2:0] hq[$];
  logic [2:0] ha, hb;
  logic [7:0] m_sr = '0, m_sw = '0;
  logic       m_sdo = 1'b0, m_upd = 1'b0;

  always @(posedge clk) begin
    hq.push_back(rst ? 3'b100 : {fs_n, sclk, sdi});
    if (hq.size() > 4) void'(hq.pop_front());
    m_upd = 1'b0;
    if (rst) begin
      m_sr = '0; m_sw = '0; m_sdo = 1'b0;
    end else if (hq.size() == 4) begin
      ha = hq[1];
      hb = hq[0];
      if (ha[2] && !hb[2]) begin
        m_sw = m_sr; m_upd = 1'b1;
      end
      if (!ha[2]) begin
        if (!ha[1] && hb[1]) m_sr = {m_sr[6:0], ha[0]};
        if (ha[1] && !hb[1]) m_sdo = m_sr[7];
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && hq.size() == 4 && !done) begin
      chk("R2 sw_en vs model", {24'd0, sw_en}, {24'd0, m_sw});
      chk("R9 upd vs model", {31'd0, upd}, {31'd0, m_upd});
      chk("R6 sdo vs model", {31'd0, sdo_low}, {31'd0, ~m_sdo});
    end
    if (upd) upd_cnt++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL R1 watchdog act=%0d exp=<20000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic send(input logic [31:0] data, input int n);
    fs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      sdi  = data[n-1-k];
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      cap  = {cap[30:0], ~sdo_low};
      sclk = 1'b0;
      repeat (HALF) @(negedge clk);
    end
    fs_n = 1'b1;
    repeat (2*HALF) @(negedge clk);
  endtask

  initial begin
    cap = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 reset switches off", {24'd0, sw_en}, 32'h0);
    chk("R9 no strobe after reset", {31'd0, upd}, 32'h0);
    chk("R7 reset sdo pulls low", {31'd0, sdo_low}, 32'h1);

    send(32'hA5, 8);
    chk("R1 byte A5 latched", {24'd0, sw_en}, 32'hA5);
    chk("R5 switch 8 on from bit 7", {31'd0, sw_en[7]}, 32'h1);
    chk("R5 switch 2 off from bit 1", {31'd0, sw_en[1]}, 32'h0);

    send(32'h3C81, 16);
    chk("R3 long frame keeps last byte", {24'd0, sw_en}, 32'h81);
    chk("R6 daisy output old byte then first byte", {16'd0, cap[15:0]}, 32'hA53C);

    send(32'hA, 4);
    chk("R3 short frame shifts older bits", {24'd0, sw_en}, 32'h1A);

    begin
      int u0;
      u0 = upd_cnt;
      sdi = 1'b1;
      for (int k = 0; k < 6; k++) begin
        sclk = 1'b1; repeat (HALF) @(negedge clk);
        sclk = 1'b0; repeat (HALF) @(negedge clk);
      end
      chk("R4 idle clocks leave switches", {24'd0, sw_en}, 32'h1A);
      send(32'h0, 0);
      chk("R10 empty frame reloads unchanged register", {24'd0, sw_en}, 32'h1A);
      chk("R9 one strobe per frame", upd_cnt - u0, 32'd1);
    end

    send(32'h100, 9);
    chk("R7 released for a 1", {31'd0, sdo_low}, 32'h0);
    chk("R3 nine-bit frame low byte", {24'd0, sw_en}, 32'h00);

    send(32'hFF, 8);
    chk("R5 all switches on", {24'd0, sw_en}, 32'hFF);
    rst = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 mid-run reset clears switches", {24'd0, sw_en}, 32'h0);
    chk("R8 mid-run reset sdo low", {31'd0, sdo_low}, 32'h1);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    send(32'h5A, 8);
    chk("R1 byte 5A latched", {24'd0, sw_en}, 32'h5A);
    chk("R5 switch 1 off from bit 0", {31'd0, sw_en[0]}, 32'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule